// File: doc/BRIEF.md
# Emergency Output Disable Controller

This block protects a three-phase power stage. It watches three active-low fault inputs. When any of them reports a fault, it removes the drive from all six PWM pads: each phase has a high-side pad and a low-side pad, and every pad enable goes low so the pads float. The same forced float applies for as long as the chip's standby request or oscillator-halt indication is high. The fault inputs themselves are ignored in that case.

Each fault input has its own detection mode. The first mode catches a single falling edge. The other three are glitch filters. A filter declares the fault only after sixteen consecutive low samples, taken at one of three rates derived from the block clock. The three inputs share one free-running prescaler. A detected fault latches a per-input flag. The flag keeps the pads floating until software clears it with a write-one-to-clear. Each flag can also be routed to a single interrupt request line.

The register interface is a plain single-cycle write port and a combinational read port. It carries no data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where `reg_we` is high. A read returns the addressed register in the same cycle.

Top module: `fault_kill_ctrl`

## Requirements
- R1: After reset, every fault flag is 0, every input is in edge mode (code 0), every interrupt enable is 0, all six `pad_en` bits are 1, and `irq` is 0.
- R2: Each fault input passes through a two-flop synchroniser. In edge mode (code 0), a falling edge on `fault_n[i]` sets flag i on the third rising clock edge after the input changes, and never on the second.
- R3: In a filter mode, a 4-bit counter per input steps on each tick of the selected rate while the synchronised input is low. The counter returns to zero on any cycle where that input is high. The flag is set on the clock after the sixteenth consecutive low sample. Shorter low runs, or runs broken by a high sample, set nothing.
- R4: The mode codes are 1 for a tick every 8 clocks, 2 for every 16 clocks and 3 for every 128 clocks. All three ticks come from one counter that runs freely from reset. The tick fires in the cycle where the counter's low 3, 4 or 7 bits are all ones.
- R5: One clock after any flag is 1, all six `pad_en` bits are 0.
- R6: One clock after `standby` or `osc_halt` is 1, all six `pad_en` bits are 0, whatever the fault inputs and flags are.
- R7: `pad_en` returns to all ones on the first clock after every flag is 0 and both `standby` and `osc_halt` are 0.
- R8: Writing address 1 with bit i set clears flag i. The clear has no effect in any cycle where input i's detection condition holds: a saturated counter with a low input in a filter mode, or a detected edge in edge mode. A detection in the same cycle as a clear leaves the flag set.
- R9: `irq` is the OR of each flag ANDed with its enable bit. The enable bits are held in address 2, bit i for input i. A flag whose enable is 0 does not raise `irq`.
- R10: Address 0 holds the mode of input i in bits [2i+1:2i]. Addresses 0, 1 and 2 read back the mode, flag and enable registers, zero-extended. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n | input | 3 | Active-low fault inputs, asynchronous |
| standby | input | 1 | Standby request; floats the pads while high |
| osc_halt | input | 1 | Oscillator-halt indication; floats the pads while high |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 6 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 6 | Read data, combinational |
| pad_en | output | 6 | Per-pad drive enable; 0 floats the pad |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: three inputs, a 4-bit sample counter, and prescaler shifts of 3, 4 and 7. With these values the slowest filter declares a fault after about 2,000 clocks, so all three rates, the edge mode and the interrupt routing fit in one short run. A behavioural model tracks the synchroniser, the prescaler phase and the sample counts cycle by cycle. This exposes off-by-one errors in the sixteen-sample count, in the tick alignment and in the one-clock release of the pads. Directed sequences also place a clear against a held fault, and a broken low run against the filter.

// File: rtl/fkc_pkg.sv
package fkc_pkg;

  // Per-input detection mode codes (field value in the mode register)
  typedef enum logic [1:0] {
    DET_EDGE  = 2'd0,
    DET_LVL_A = 2'd1,
    DET_LVL_B = 2'd2,
    DET_LVL_C = 2'd3
  } det_mode_e;

  localparam int N_RATES = 3;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_IE   = 2'd2;

endpackage

// File: rtl/fkc_prescaler.sv
module fkc_prescaler
  import fkc_pkg::*;
#(
  parameter int SH_A = 3,
  parameter int SH_B = 4,
  parameter int SH_C = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [N_RATES-1:0] tick
);

  localparam int CW = (SH_C > SH_B) ? ((SH_C > SH_A) ? SH_C : SH_A)
                                    : ((SH_B > SH_A) ? SH_B : SH_A);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < N_RATES; k++) begin : g_tick
    localparam int S = (k == 0) ? SH_A : ((k == 1) ? SH_B : SH_C);
    assign tick[k] = (cnt_q[S-1:0] == {S{1'b1}});
  end

  // Slower ticks coincide with faster ones (shifts are ordered)
  for (genvar k = 1; k < N_RATES; k++) begin : g_nest
    assert_tick_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |-> tick[k-1]);
  end

endmodule

// File: rtl/fkc_sync.sv
module fkc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '1;
    end else begin
      st_q[0] <= din;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign dout = st_q[STAGES-1];

endmodule

// File: rtl/fkc_detect.sv
module fkc_detect
  import fkc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  det_mode_e          mode,
  input  logic               s_n,
  input  logic [N_RATES-1:0] tick,
  input  logic               clr,
  output logic               flag,
  output logic               hold
);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          lvl, sel_tick, full, hit;

  assign lvl  = (mode != DET_EDGE);
  assign full = (cnt_q == {CW{1'b1}});

  always_comb begin
    unique case (mode)
      DET_LVL_A: sel_tick = tick[0];
      DET_LVL_B: sel_tick = tick[1];
      DET_LVL_C: sel_tick = tick[2];
      default:   sel_tick = 1'b0;
    endcase
  end

  assign hit  = lvl ? (sel_tick & ~s_n & full) : (prev_q & ~s_n);
  assign hold = lvl ? (~s_n & full) : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= s_n;
      if (!lvl || s_n)         cnt_q <= '0;
      else if (sel_tick && !full) cnt_q <= cnt_q + 1'b1;
      flag_q <= hit | (flag_q & ~(clr & ~hold));
    end
  end

  assign flag = flag_q;

  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && s_n) |=> (cnt_q == '0));

  assert_lvl_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(lvl)) |-> ($past(cnt_q) == {CW{1'b1}} && !$past(s_n)));

  assert_edge_needs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && !$past(lvl)) |-> ($past(prev_q) && !$past(s_n)));

  assert_clear_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr && hold) |=> flag_q);

endmodule

// File: rtl/fault_kill_ctrl.sv
module fault_kill_ctrl
  import fkc_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_PH  = 3,
  parameter int SMP_W = 4,
  parameter int SH_A  = 3,
  parameter int SH_B  = 4,
  parameter int SH_C  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     fault_n,
  input  logic                standby,
  input  logic                osc_halt,
  input  logic                reg_we,
  input  logic [1:0]          reg_waddr,
  input  logic [2*N_IN-1:0]   reg_wdata,
  input  logic [1:0]          reg_raddr,
  output logic [2*N_IN-1:0]   reg_rdata,
  output logic [2*N_PH-1:0]   pad_en,
  output logic                irq
);

  localparam int DW    = 2 * N_IN;
  localparam int N_PAD = 2 * N_PH;

  logic [N_IN-1:0]    s_n, flag, hold, clr, ie_q;
  logic [DW-1:0]      mode_q;
  logic [N_RATES-1:0] tick;
  logic               kill_q;

  fkc_sync #(.N(N_IN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(fault_n), .dout(s_n)
  );

  fkc_prescaler #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign clr = (reg_we && reg_waddr == ADDR_FLAG) ? reg_wdata[N_IN-1:0] : '0;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    fkc_detect #(.CW(SMP_W)) u_det (
      .clk(clk), .rst_n(rst_n),
      .mode(det_mode_e'(mode_q[2*i +: 2])),
      .s_n(s_n[i]), .tick(tick), .clr(clr[i]),
      .flag(flag[i]), .hold(hold[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ie_q   <= '0;
      kill_q <= 1'b0;
    end else begin
      if (reg_we && reg_waddr == ADDR_MODE) mode_q <= reg_wdata;
      if (reg_we && reg_waddr == ADDR_IE)   ie_q   <= reg_wdata[N_IN-1:0];
      kill_q <= (|flag) | standby | osc_halt;
    end
  end

  assign pad_en = {N_PAD{~kill_q}};
  assign irq    = |(flag & ie_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_raddr)
      ADDR_MODE: reg_rdata = mode_q;
      ADDR_FLAG: reg_rdata[N_IN-1:0] = flag;
      ADDR_IE:   reg_rdata[N_IN-1:0] = ie_q;
      default:   reg_rdata = '0;
    endcase
  end

  assert_kill_on_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag) |=> (pad_en == '0));

  assert_kill_on_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (standby || osc_halt) |=> (pad_en == '0));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|flag) && !standby && !osc_halt) |=> (pad_en == {N_PAD{1'b1}}));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flag));

endmodule

// File: tb/sim_fault_kill_ctrl.sv
module sim_fault_kill_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fault_n = 3'b111;
  logic       standby = 1'b0, osc_halt = 1'b0;
  logic       we = 1'b0;
  logic [1:0] waddr = 2'd0, raddr = 2'd1;
  logic [5:0] wdata = 6'd0;
  logic [5:0] rdata;
  logic [5:0] pad_en;
  logic       irq;

  int checks = 0, errors = 0, cycles = 0;

  fault_kill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .standby(standby),
    .osc_halt(osc_halt), .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rdata), .pad_en(pad_en), .irq(irq)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [2:0] m_s1 = 3'b111, m_s2 = 3'b111, m_pv = 3'b111, m_flag = 0, m_ie = 0;
  bit [5:0] m_mode = 0;
  int       m_cnt [3];
  int       m_pre = 0;
  bit       m_kill = 0;
  int       shv [3] = '{3, 4, 7};

  function automatic int m_read(input int a);
    case (a)
      0: return int'(m_mode);
      1: return int'(m_flag);
      2: return int'(m_ie);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_pv = 3'b111;
      m_flag = 0; m_ie = 0; m_mode = 0; m_pre = 0; m_kill = 0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      bit [2:0] t;
      bit [2:0] nflag;
      for (int k = 0; k < 3; k++) begin
        int msk;
        msk = (1 << shv[k]) - 1;
        t[k] = ((m_pre & msk) == msk);
      end
      for (int i = 0; i < 3; i++) begin
        int md;
        bit low, det, hld, clr;
        md  = int'(m_mode[2*i +: 2]);
        low = !m_s2[i];
        det = 0; hld = 0;
        if (md == 0) begin
          det = m_pv[i] && low; hld = det; m_cnt[i] = 0;
        end else begin
          hld = low && (m_cnt[i] == 15);
          if (!low) m_cnt[i] = 0;
          else if (t[md-1]) begin
            if (m_cnt[i] == 15) det = 1;
            else m_cnt[i] = m_cnt[i] + 1;
          end
        end
        clr = we && (waddr == 2'd1) && wdata[i];
        nflag[i] = det | (m_flag[i] & !(clr & !hld));
      end
      m_kill = (|m_flag) | standby | osc_halt;
      m_flag = nflag;
      if (we && waddr == 2'd0) m_mode = wdata;
      if (we && waddr == 2'd2) m_ie = wdata[2:0];
      m_pv = m_s2; m_s2 = m_s1; m_s1 = fault_n;
      m_pre = (m_pre + 1) % 128;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R5/R6/R7 pad_en vs model", int'(pad_en), m_kill ? 0 : 6'h3f);
      chk("R9 irq vs model", int'(irq), int'(|(m_flag & m_ie)));
      chk("R10 rdata vs model", int'(rdata), m_read(int'(raddr)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; waddr = 2'(a); wdata = 6'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    raddr = 2'(a);
    #1 v = int'(rdata);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 pad_en", int'(pad_en), 6'h3f);
    chk("R1 irq", int'(irq), 0);
    rd(0, v); chk("R1 mode", v, 0);
    rd(2, v); chk("R1 ie", v, 0);
    rd(1, v); chk("R1 flags", v, 0);

    // R2 edge mode on input 0
    fault_n[0] = 1'b0;
    cyc(2); rd(1, v); chk("R2 flag not yet", v, 0);
    cyc(1); rd(1, v); chk("R2 flag set", v, 1);
    chk("R5 pads before kill", int'(pad_en), 6'h3f);
    cyc(1); chk("R5 pads floated", int'(pad_en), 0);
    fault_n[0] = 1'b1;
    chk("R9 irq masked", int'(irq), 0);
    wr(2, 1); chk("R9 irq enabled", int'(irq), 1);
    wr(1, 1); rd(1, v); chk("R8 clear edge flag", v, 0);
    chk("R7 pads still off", int'(pad_en), 0);
    cyc(1); chk("R7 pads released", int'(pad_en), 6'h3f);

    // R3 filter at /8 on input 1
    wr(0, 6'b000100); rd(0, v); chk("R10 mode readback", v, 4);
    rd(1, v);
    fault_n[1] = 1'b0;
    cyc(3); rd(1, v); chk("R3 short low ignored", v, 0);
    cyc(14*8 - 3); rd(1, v); chk("R3 below sixteen samples", v, 0);
    cyc(3*8 + 4); rd(1, v); chk("R3 sixteen samples", v, 2);
    chk("R9 irq only enabled flag", int'(irq), 0);
    wr(1, 2); rd(1, v); chk("R8 clear blocked while held", v, 2);
    fault_n[1] = 1'b1; cyc(4);
    wr(1, 2); rd(1, v); chk("R8 clear after release", v, 0);
    cyc(1);
    fault_n[1] = 1'b0; cyc(12*8);
    fault_n[1] = 1'b1; cyc(3);
    fault_n[1] = 1'b0; cyc(14*8);
    rd(1, v); chk("R3 broken run ignored", v, 0);
    chk("R3 pads kept on", int'(pad_en), 6'h3f);
    fault_n[1] = 1'b1; cyc(4);

    // R4 slower rates on input 2
    wr(0, 6'b100100); rd(1, v);
    fault_n[2] = 1'b0;
    cyc(14*16); rd(1, v); chk("R4 /16 early", v, 0);
    cyc(3*16 + 4); rd(1, v); chk("R4 /16 detect", v, 4);
    fault_n[2] = 1'b1; cyc(4); wr(1, 4);
    wr(0, 6'b110100); rd(0, v); chk("R10 mode readback /128", v, 6'h34);
    rd(1, v);
    fault_n[2] = 1'b0;
    cyc(14*128); rd(1, v); chk("R4 /128 early", v, 0);
    cyc(3*128 + 4); rd(1, v); chk("R4 /128 detect", v, 4);
    fault_n[2] = 1'b1; cyc(4); wr(1, 4);
    rd(1, v); chk("R8 clear /128 flag", v, 0);
    cyc(1);

    // R6/R7 standby and oscillator halt
    chk("R7 pads on before standby", int'(pad_en), 6'h3f);
    standby = 1'b1; cyc(1); chk("R6 standby floats", int'(pad_en), 0);
    standby = 1'b0; cyc(1); chk("R7 standby released", int'(pad_en), 6'h3f);
    osc_halt = 1'b1; cyc(1); chk("R6 halt floats", int'(pad_en), 0);
    osc_halt = 1'b0; cyc(1); chk("R7 halt released", int'(pad_en), 6'h3f);
    rd(3, v); chk("R10 unused address", v, 0);
    rd(1, v);
    cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule